// File: doc/BRIEF.md
# APB Two-Channel Down-Counter Timer with Interrupt Test Override

This block is an APB slave that holds two independent down-counting timer channels inside a 4 KB address window. Each channel has its own register bank, which sets a reload value, a running count, and a control word covering enable, one-shot, 16/32-bit width, free-run/periodic mode, prescaling and interrupt mask. A channel raises a sticky raw interrupt when its count steps from one to zero. Software clears that interrupt by writing the channel's clear offset.

Each channel drives its own interrupt line, and a third line carries the OR of the two. An integration-test control can take over both per-channel lines. While it is set, each line follows a bit that software writes, so interrupt wiring can be checked without running the counters. A short table of read-only identification bytes sits at the top of the window. Every other offset reads as zero and ignores writes.

All accesses finish without wait states. Read data is captured at the clock edge that ends the setup phase and is held through the access phase. The interrupt lines are plain level outputs.

Top module: `apb_dual_timer`

## Requirements
- R1: Every access completes with zero wait states: `pready` is high and `pslverr` is low. Read data presented in the access phase comes from the address given in the setup phase. A write takes effect at the clock edge where `psel`, `penable` and `pwrite` are all high.
- R2: Channel 0 decodes at byte offsets 0x00–0x1F and channel 1 at 0x20–0x3F. Within a bank, the offsets are: 0x00 reload, 0x04 count, 0x08 control, 0x0C interrupt clear (write only, reads zero), 0x10 raw status (bit 0), 0x14 masked status (bit 0), 0x18 background reload.
- R3: Writing 0x00 sets both the reload value and the count. Writing 0x18 sets only the reload value. Reads of 0x00 and 0x18 both return the stored reload value.
- R4: An enabled channel decrements once per prescaled tick. A step from 1 to 0 sets raw status. At zero, a one-shot channel (control bit 0 = 1) holds. Otherwise the channel reloads on the next tick: from the reload value in periodic mode (bit 6 = 1), or to all ones in free-run mode (bit 6 = 0). Count 0 is held while enable (bit 7) is clear.
- R5: Masked status equals raw status ANDed with control bit 5. Any write to the interrupt-clear offset clears raw status.
- R6: Control resets to 0x20. Only bits 0,1,2,3,5,6,7 are stored, so writing 0x1F reads back 0x0F. The reload value resets to 0 and the count to 0xFFFFFFFF.
- R7: The test control at 0xF00 stores bit 0 and reads back that bit. The test output at 0xF04 stores bits 1:0 and reads as zero. While test control bit 0 is set, channel n's interrupt line equals test output bit n. Otherwise it equals channel n's masked status.
- R8: `irq_any` is the OR of the two per-channel interrupt lines, in either mode.
- R9: Offsets 0xFD0 through 0xFFC read, in ascending word order, the bytes 04,00,00,00,23,B8,1B,00,0D,F0,05,B1 in bits 7:0, with upper bits zero.
- R10: Both test registers reset to zero. Reads of any unmapped offset return zero, and writes to unmapped offsets change no state.
- R11: With control bit 1 = 0 (16-bit), only count bits 15:0 decrement, compare and reload. Bits 31:16 keep their value.
- R12: Control bits 3:2 select the prescale divisor: 0 → every clock, 1 → every 16 clocks, 2 or 3 → every 256 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq_chan | output | 2 | Per-channel interrupt lines (bit n = channel n) |
| irq_any | output | 1 | OR of both channel lines |

## Verification
The hardest case to reach is the test override landing while a live interrupt is already pending, and then being released. The stimulus runs channel 0 as a one-shot until its masked interrupt is high. It then enables test mode with test bits that disagree with the live state, and checks that channel 0's line drops while channel 1's line rises. Finally it clears test mode and checks that the pending live interrupt reappears unchanged. The reload-versus-count split gets the same treatment: the counter is frozen first, so a background-reload write can be shown to leave the count untouched.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int NCH   = 2;
  localparam int DW    = 32;
  localparam int PW    = 8;
  localparam int CW    = 8;

  // control bit positions
  localparam int C_ONESHOT = 0;
  localparam int C_WIDE    = 1;
  localparam int C_PRE_LO  = 2;
  localparam int C_INTEN   = 5;
  localparam int C_PERIOD  = 6;
  localparam int C_RUN     = 7;
  localparam logic [CW-1:0] CTRL_KEEP  = 8'hEF;
  localparam logic [CW-1:0] CTRL_RESET = 8'h20;

  // register index within a bank (word offset)
  localparam logic [2:0] RI_RELOAD = 3'd0;
  localparam logic [2:0] RI_COUNT  = 3'd1;
  localparam logic [2:0] RI_CTRL   = 3'd2;
  localparam logic [2:0] RI_CLR    = 3'd3;
  localparam logic [2:0] RI_RAW    = 3'd4;
  localparam logic [2:0] RI_MSK    = 3'd5;
  localparam logic [2:0] RI_BGRLD  = 3'd6;

  // word addresses of the shared registers
  localparam logic [9:0] WA_TCTRL = 10'h3C0;
  localparam logic [9:0] WA_TOUT  = 10'h3C1;
  localparam logic [9:0] WA_ID0   = 10'h3F4;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:  id_byte = 8'h04;
      4'd4:  id_byte = 8'h23;
      4'd5:  id_byte = 8'hB8;
      4'd6:  id_byte = 8'h1B;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtim_prescaler.sv
module dtim_prescaler #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam logic [PW-1:0] LIM16 = PW'(15);
  localparam logic [PW-1:0] LIMMX = {PW{1'b1}};

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;

  always_comb begin
    case (sel)
      2'd0:    limit = '0;
      2'd1:    limit = LIM16;
      default: limit = LIMMX;
    endcase
  end

  assign tick = run && (pcnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pcnt_q <= '0;
    else if (!run || restart || tick) pcnt_q <= '0;
    else                              pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/dtim_channel.sv
module dtim_channel
  import dtim_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    widx,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    ridx,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int HW = DW / 2;

  logic [DW-1:0] reload_q, cnt_q;
  logic [CW-1:0] ctrl_q;
  logic          raw_q;
  logic          tick, load_wr, wide, run;
  logic [DW-1:0] cur, dec_val, rl_src, rl_val;

  assign load_wr = we && (widx == RI_RELOAD);
  assign wide    = ctrl_q[C_WIDE];
  assign run     = ctrl_q[C_RUN];

  dtim_prescaler #(.PW(PW)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(load_wr),
    .sel(ctrl_q[C_PRE_LO+1:C_PRE_LO]), .tick(tick)
  );

  always_comb begin
    cur     = wide ? cnt_q : {{HW{1'b0}}, cnt_q[HW-1:0]};
    dec_val = wide ? cnt_q - 1'b1 : {cnt_q[DW-1:HW], cnt_q[HW-1:0] - 1'b1};
    rl_src  = ctrl_q[C_PERIOD] ? reload_q : {DW{1'b1}};
    rl_val  = wide ? rl_src : {cnt_q[DW-1:HW], rl_src[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= {DW{1'b1}};
      ctrl_q   <= CTRL_RESET;
      raw_q    <= 1'b0;
    end else begin
      if (load_wr) begin
        reload_q <= wdata;
        cnt_q    <= wdata;
      end else begin
        if (we && widx == RI_BGRLD) reload_q <= wdata;
        if (run && tick) begin
          if (cur == '0) begin
            if (!ctrl_q[C_ONESHOT]) cnt_q <= rl_val;
          end else begin
            cnt_q <= dec_val;
          end
        end
      end
      if (we && widx == RI_CTRL) ctrl_q <= wdata[CW-1:0] & CTRL_KEEP;
      if (!load_wr && run && tick && cur == DW'(1)) raw_q <= 1'b1;
      else if (we && widx == RI_CLR)                raw_q <= 1'b0;
    end
  end

  assign irq = raw_q && ctrl_q[C_INTEN];

  always_comb begin
    case (ridx)
      RI_RELOAD, RI_BGRLD: rdata = reload_q;
      RI_COUNT:            rdata = cnt_q;
      RI_CTRL:             rdata = {{(DW-CW){1'b0}}, ctrl_q};
      RI_RAW:              rdata = {{(DW-1){1'b0}}, raw_q};
      RI_MSK:              rdata = {{(DW-1){1'b0}}, irq};
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtim_irq_select.sv
module dtim_irq_select #(
  parameter int N = 2
) (
  input  logic         test_en,
  input  logic [N-1:0] test_out,
  input  logic [N-1:0] live,
  output logic [N-1:0] irq,
  output logic         irq_or
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign irq[i] = test_en ? test_out[i] : live[i];
  end
  assign irq_or = |irq;
endmodule

// File: rtl/apb_dual_timer.sv
module apb_dual_timer
  import dtim_pkg::*;
(
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic [1:0]  irq_chan,
  output logic        irq_any
);
  logic [9:0]     waddr;
  logic           wr_acc, rd_setup, in_bank;
  logic           test_en_q;
  logic [NCH-1:0] test_out_q;
  logic [NCH-1:0] live_irq;
  logic [DW-1:0]  ch_rdata [NCH];
  logic [DW-1:0]  rd_mux;
  logic [9:0]     id_off;

  assign waddr    = paddr[11:2];
  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign in_bank  = (waddr[9:4] == 6'd0);
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dtim_channel #(.DW(DW), .PW(PW)) ch_i (
      .clk(pclk), .rst_n(presetn),
      .we(wr_acc && in_bank && (waddr[3] == c[0])),
      .widx(waddr[2:0]), .wdata(pwdata),
      .ridx(waddr[2:0]), .rdata(ch_rdata[c]),
      .irq(live_irq[c])
    );
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      test_en_q  <= 1'b0;
      test_out_q <= '0;
    end else if (wr_acc) begin
      if (waddr == WA_TCTRL) test_en_q  <= pwdata[0];
      if (waddr == WA_TOUT)  test_out_q <= pwdata[NCH-1:0];
    end
  end

  assign id_off = waddr - WA_ID0;

  always_comb begin
    rd_mux = '0;
    if (in_bank)                rd_mux = ch_rdata[waddr[3]];
    else if (waddr == WA_TCTRL) rd_mux = {{(DW-1){1'b0}}, test_en_q};
    else if (waddr >= WA_ID0)   rd_mux = {{(DW-8){1'b0}}, id_byte(id_off[3:0])};
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)      prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

  dtim_irq_select #(.N(NCH)) sel_i (
    .test_en(test_en_q), .test_out(test_out_q), .live(live_irq),
    .irq(irq_chan), .irq_or(irq_any)
  );
endmodule

// File: rtl/apb_dual_timer_chk.sv
module apb_dual_timer_chk (
  input logic        pclk,
  input logic        presetn,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic [1:0]  irq_chan,
  input logic        irq_any,
  input logic        test_en,
  input logic [1:0]  test_out,
  input logic [1:0]  live_irq
);
  assert_test_override_R7: assert property (@(posedge pclk) disable iff (!presetn)
    test_en |-> (irq_chan == test_out));
  assert_live_path_R7: assert property (@(posedge pclk) disable iff (!presetn)
    !test_en |-> (irq_chan == live_irq));
  assert_test_write_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == 12'hF00) |=> (test_en == $past(pwdata[0])));
  assert_combined_or_R8: assert property (@(posedge pclk) disable iff (!presetn)
    irq_any == (irq_chan[0] | irq_chan[1]));
  assert_id_read_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable && !pwrite && paddr == 12'hFE4) |=> (prdata == 32'h0000_00B8));
  assert_unmapped_zero_R10: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable && !pwrite && paddr == 12'h800) |=> (prdata == 32'h0));
endmodule

bind apb_dual_timer apb_dual_timer_chk chk_i (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .irq_chan(irq_chan), .irq_any(irq_any), .test_en(test_en_q),
  .test_out(test_out_q), .live_irq(live_irq)
);

// File: tb/apb_dual_timer_tb_top.sv
module apb_dual_timer_tb_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  irq_chan;
  logic        irq_any;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 pclk = ~pclk;

  apb_dual_timer dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_chan(irq_chan), .irq_any(irq_any)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    check(pready === 1'b1 && pslverr === 1'b0, "R1", {30'b0, pready, pslverr}, 32'h2);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    d = prdata;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge pclk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h008, v); check(v == 32'h20, "R6 ctrl reset", v, 32'h20);
    rd(12'h004, v); check(v == 32'hFFFF_FFFF, "R6 count reset", v, 32'hFFFF_FFFF);
    rd(12'h020, v); check(v == 32'h0, "R6 reload reset", v, 32'h0);
    rd(12'hF00, v); check(v == 32'h0, "R10 test ctrl reset", v, 32'h0);
    check(irq_chan == 2'b00 && irq_any == 1'b0, "R10 irq reset", {29'b0, irq_any, irq_chan}, 0);
  endtask

  task automatic t_ids;
    logic [31:0] v;
    logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 12; k++) begin
      rd(12'hFD0 + 12'(4 * k), v);
      check(v == {24'b0, exp_id[k]}, "R9 id byte", v, {24'b0, exp_id[k]});
    end
    rd(12'h800, v); check(v == 0, "R10 unmapped read", v, 0);
    rd(12'h01C, v); check(v == 0, "R10 bank hole read", v, 0);
    rd(12'h00C, v); check(v == 0, "R2 clear offset reads zero", v, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(12'h000, 32'd10);
    wr(12'h008, 32'hA3);
    idle(25);
    rd(12'h004, v); check(v == 0, "R4 one-shot holds zero", v, 0);
    rd(12'h010, v); check(v == 1, "R4 raw set", v, 1);
    rd(12'h014, v); check(v == 1, "R5 masked set", v, 1);
    check(irq_chan == 2'b01 && irq_any, "R8 ch0 line and any", {29'b0, irq_any, irq_chan}, 32'h5);
    wr(12'h00C, 32'h0);
    rd(12'h010, v); check(v == 0, "R5 clear raw", v, 0);
    check(irq_chan == 2'b00 && !irq_any, "R5 line cleared", {29'b0, irq_any, irq_chan}, 0);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(12'h020, 32'd4);
    wr(12'h028, 32'hC2);
    idle(12);
    rd(12'h030, v); check(v == 1, "R4 periodic raw", v, 1);
    rd(12'h034, v); check(v == 0, "R5 masked off", v, 0);
    check(irq_chan[1] == 1'b0, "R5 line masked", {31'b0, irq_chan[1]}, 0);
    rd(12'h024, v); check(v <= 4, "R4 periodic reloads from reload", v, 4);
    wr(12'h028, 32'hE2);
    rd(12'h034, v); check(v == 1, "R5 masked on", v, 1);
    wr(12'h02C, 32'h0);
    idle(8);
    rd(12'h030, v); check(v == 1, "R4 periodic fires again", v, 1);
    wr(12'h028, 32'h0);
    wr(12'h02C, 32'h0);
  endtask

  task automatic t_freerun;
    logic [31:0] v;
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h82);
    idle(10);
    rd(12'h004, v); check(v > 32'hFFFF_FFE0, "R4 free-run wraps to all ones", v, 32'hFFFF_FFF0);
    rd(12'h010, v); check(v == 1, "R4 free-run raw", v, 1);
    wr(12'h008, 32'h0);
    wr(12'h00C, 32'h0);
  endtask

  task automatic t_narrow_and_bg;
    logic [31:0] v, v2;
    wr(12'h000, 32'h1234_0003);
    wr(12'h008, 32'h80);
    idle(10);
    wr(12'h008, 32'h0);
    rd(12'h004, v);
    check(v[31:16] == 16'h1234, "R11 upper half kept", v, 32'h1234_FFF0);
    check(v[15:0] > 16'hFFE0, "R11 low half wraps", v, 32'h1234_FFF0);
    wr(12'h018, 32'h55);
    rd(12'h000, v2); check(v2 == 32'h55, "R3 reload via load offset", v2, 32'h55);
    rd(12'h018, v2); check(v2 == 32'h55, "R3 reload via background offset", v2, 32'h55);
    rd(12'h004, v2); check(v2 == v, "R3 background leaves count", v2, v);
    wr(12'h000, 32'h77);
    rd(12'h004, v2); check(v2 == 32'h77, "R3 load sets count", v2, 32'h77);
    wr(12'h00C, 32'h0);
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] v;
    wr(12'h028, 32'h1F);
    rd(12'h028, v); check(v == 32'h0F, "R6 reserved bit dropped", v, 32'h0F);
    wr(12'h028, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(12'h020, 32'd100);
    wr(12'h028, 32'h87);
    idle(160);
    rd(12'h024, v); check(v >= 88 && v <= 92, "R12 divide by 16", v, 90);
    wr(12'h028, 32'h0);
    wr(12'h020, 32'd100);
    wr(12'h028, 32'h8B);
    idle(200);
    rd(12'h024, v); check(v == 100, "R12 divide by 256 early", v, 100);
    idle(120);
    rd(12'h024, v); check(v == 99, "R12 divide by 256 one tick", v, 99);
    wr(12'h028, 32'h0);
    wr(12'h020, 32'd100);
    wr(12'h028, 32'h8F);
    idle(200);
    rd(12'h024, v); check(v == 100, "R12 code 3 as 256", v, 100);
    wr(12'h028, 32'h0);
  endtask

  task automatic t_test_mode;
    logic [31:0] v;
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hA3);
    idle(8);
    check(irq_chan == 2'b01, "R7 live ch0 pending", {30'b0, irq_chan}, 1);
    wr(12'hF04, 32'h2);
    check(irq_chan == 2'b01, "R7 test out inert while off", {30'b0, irq_chan}, 1);
    wr(12'hF00, 32'h1);
    check(irq_chan == 2'b10, "R7 override", {30'b0, irq_chan}, 2);
    check(irq_any == 1'b1, "R8 any in test mode", {31'b0, irq_any}, 1);
    rd(12'hF00, v); check(v == 1, "R7 test ctrl readback", v, 1);
    rd(12'hF04, v); check(v == 0, "R7 test out reads zero", v, 0);
    wr(12'hF04, 32'h0);
    check(irq_chan == 2'b00 && !irq_any, "R8 all low in test mode", {29'b0, irq_any, irq_chan}, 0);
    wr(12'hF00, 32'h0);
    check(irq_chan == 2'b01 && irq_any, "R7 live restored", {29'b0, irq_any, irq_chan}, 5);
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'hF08, 32'hFFFF_FFFF);
    rd(12'h008, v); check(v == 32'hA3, "R10 unmapped write ignored ctrl", v, 32'hA3);
    rd(12'hF00, v); check(v == 0, "R10 unmapped write ignored test", v, 0);
    check(irq_chan == 2'b01, "R10 irq unchanged", {30'b0, irq_chan}, 1);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    t_reset;
    t_ids;
    t_oneshot;
    t_periodic;
    t_freerun;
    t_narrow_and_bg;
    t_ctrl_mask;
    t_prescale;
    t_test_mode;
    done = 1;
    report;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      report;
    end
  end
endmodule